// File: doc/BRIEF.md
# Multichannel DAC Register Interface

This block is the digital front end of an eight-channel DAC. A host writes to it over a parallel bus. Each write carries a mode input, a three-bit channel address, a register-select bit and a data word. With the mode input low, a write goes to one of two control registers. The first is a package-wide system control register, which sets the loading format, the input coding, power-down, package standby and a one-shot system clear. The second is a per-channel control register, which holds a bias-source select, a main/sub routing bit, a channel standby bit and a channel clear request. With the mode input high, a write carries a code for the addressed channel.

Every channel keeps two codes, a main code and a sub code. Each code has an input register and an output register. A code arrives either as one full-width write or as two byte-wide writes. The output codes change only when the package-wide load strobe is asserted, when every channel copies its input registers to its output registers at once. Clears reset only the main code. The clear value depends on the input coding. Codes are held internally as offset binary, so a twos-complement input has its MSB inverted on entry.

The block drives the output codes, the per-channel bias selects, the clear-pending flags and a combined per-channel "off" flag to the analog section.

Top module: `dacif_top`

## Requirements
- R1: After reset, every main and sub output code is 0. Every bias select, clear-pending flag, byte-format flag, twos-complement flag and the power-down flag read 0. Every chan_off_o bit reads 1, because package standby is set at reset.
- R2: A write with mode_i=0 and sel_i=1 loads the control register of channel addr_i and no other channel. data_i[1:0] is the bias select, data_i[2] routes later codes to the sub register, data_i[3] puts the channel in standby and data_i[4] requests a channel clear.
- R3: A write with mode_i=0 and sel_i=0 loads the system control register. data_i[0] selects byte format, data_i[1] selects twos-complement coding, data_i[2] selects power-down and data_i[3] selects package standby. chan_off_o[i] equals power-down OR package standby OR the standby bit of channel i.
- R4: In word format, a data write (mode_i=1) with the channel routing bit at 0 stores data_i in the main input register of channel addr_i. main_code_o stays unchanged until a load_i cycle, after which it shows the stored code.
- R5: With the channel routing bit at 1, a word-format data write stores the code in the sub input register instead. sub_code_o follows it only after load_i.
- R6: Under twos-complement coding, every stored code is the written code with its MSB inverted. This holds for codes from a word write and for codes assembled from two byte writes.
- R7: In byte format, the first data write supplies code bits 7..0 in data_i[7:0] and changes no code. The second data write supplies code bits 9..8 in data_i[2:1] and chooses the target in data_i[0], with 0 for main and 1 for sub. The code is stored only on the second write.
- R8: A channel clear request stays pending (clr_pend_o=1) and leaves main_code_o unchanged until load_i. That load sets the channel's main input and output codes to 0x000 under offset binary coding, or to 0x200 under twos complement, and drops the pending flag. The sub code is unchanged.
- R9: A system control write with data_i[4]=1 sets the main input and output codes of all channels to the clear value of the coding written in that same write, on the next cycle. Sub codes are untouched.
- R10: A load_i with no code written since the previous load leaves every output code unchanged. A data write (mode_i=1) leaves every control field unchanged.
- R11: Any system control write restarts the byte sequence, so the next data write is taken as a first byte.
- R12: When load_i and a data write fall in the same cycle, the load transfers the input register contents from before that write. The new code reaches the output only on a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| mode_i | input | 1 | 1 = code write, 0 = control write |
| sel_i | input | 1 | Control write target: 0 = system, 1 = channel |
| addr_i | input | 3 | Channel address |
| data_i | input | 10 | Write data |
| load_i | input | 1 | Load strobe, copies input codes to output codes |
| fmt_byte_o | output | 1 | Byte loading format active |
| coding_twos_o | output | 1 | Twos-complement input coding active |
| pwrdn_o | output | 1 | Package power-down |
| chan_off_o | output | 8 | Per-channel off flag |
| bias_sel_o | output | 16 | Per-channel bias select, 2 bits per channel |
| clr_pend_o | output | 8 | Per-channel clear pending |
| main_code_o | output | 80 | Main output codes, channel i at bits 10*i+9..10*i |
| sub_code_o | output | 80 | Sub output codes, same layout |

## Verification
The assertions assume that wr_i and load_i are clean single-cycle strobes free of X values. They also assume that a system clear arrives only through a system control write, so that any change of a main code can be traced to load_i or to that write. The stimulus drives every input one time unit after a rising edge, holds each strobe for exactly one cycle and returns all inputs to idle afterwards. Every address it uses names an existing channel. Loads and writes in the same cycle are issued on purpose to exercise the ordering rule.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // system control field positions in the write data
    localparam int SYS_BYTE_BIT  = 0;
    localparam int SYS_TWOS_BIT  = 1;
    localparam int SYS_PD_BIT    = 2;
    localparam int SYS_STBY_BIT  = 3;
    localparam int SYS_CLR_BIT   = 4;

    // channel control field positions in the write data
    localparam int CH_BIAS_LSB   = 0;
    localparam int CH_BIAS_W     = 2;
    localparam int CH_SUB_BIT    = 2;
    localparam int CH_STBY_BIT   = 3;
    localparam int CH_CLR_BIT    = 4;
    localparam int CTL_W         = 5;

    // low part carried by the first byte write
    localparam int BYTE_W        = 8;

    typedef struct packed {
        logic byte_fmt;
        logic twos;
        logic pwrdn;
        logic pkg_stby;
    } sys_ctrl_t;

    typedef struct packed {
        logic [CH_BIAS_W-1:0] bias;
        logic                 sub_sel;
        logic                 stby;
        logic                 clr_pend;
    } ch_ctrl_t;

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode #(
    parameter int NCH = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic          wr_i,
    input  logic          mode_i,
    input  logic          sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic          clr_bit_i,
    output logic          sys_we_o,
    output logic          sys_clr_o,
    output logic [NCH-1:0] chctl_we_o,
    output logic          dat_we_o
);

    always_comb begin
        sys_we_o   = wr_i && !mode_i && !sel_i;
        sys_clr_o  = sys_we_o && clr_bit_i;
        dat_we_o   = wr_i && mode_i;
        chctl_we_o = '0;
        for (int i = 0; i < NCH; i++) begin
            chctl_we_o[i] = wr_i && !mode_i && sel_i && (addr_i == AW'(i));
        end
    end

endmodule

// File: rtl/dacif_assemble.sv
module dacif_assemble
    import dacif_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CODE_W = 10,
    localparam int AW    = $clog2(NCH),
    localparam int HI_W  = CODE_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_we_i,
    input  logic              sys_we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [CODE_W-1:0] data_i,
    input  logic              byte_fmt_i,
    input  logic              twos_i,
    input  logic [NCH-1:0]    sub_sel_i,
    output logic [NCH-1:0]    code_we_o,
    output logic              code_sub_o,
    output logic [CODE_W-1:0] code_val_o
);

    typedef struct packed {
        logic              second;
        logic [BYTE_W-1:0] lo;
    } asm_t;

    asm_t              s_d, s_q;
    logic              fire;
    logic [CODE_W-1:0] raw;

    always_comb begin
        s_d        = s_q;
        fire       = 1'b0;
        raw        = '0;
        code_sub_o = 1'b0;
        if (sys_we_i) begin
            s_d.second = 1'b0;
        end else if (dat_we_i) begin
            if (!byte_fmt_i) begin
                raw        = data_i;
                code_sub_o = sub_sel_i[addr_i];
                fire       = 1'b1;
            end else if (!s_q.second) begin
                s_d.second = 1'b1;
                s_d.lo     = data_i[BYTE_W-1:0];
            end else begin
                s_d.second = 1'b0;
                raw        = {data_i[HI_W:1], s_q.lo};
                code_sub_o = data_i[0];
                fire       = 1'b1;
            end
        end
        code_val_o = twos_i ? {~raw[CODE_W-1], raw[CODE_W-2:0]} : raw;
        for (int i = 0; i < NCH; i++) begin
            code_we_o[i] = fire && (addr_i == AW'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dacif_channel.sv
module dacif_channel
    import dacif_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic              code_we_i,
    input  logic              code_sub_i,
    input  logic [CODE_W-1:0] code_val_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] clr_val_i,
    input  logic              sys_clr_i,
    input  logic [CODE_W-1:0] sys_clr_val_i,
    output ch_ctrl_t          ctl_o,
    output logic [CODE_W-1:0] main_o,
    output logic [CODE_W-1:0] sub_o
);

    typedef struct packed {
        ch_ctrl_t          ctl;
        logic [CODE_W-1:0] main_in;
        logic [CODE_W-1:0] sub_in;
        logic [CODE_W-1:0] main_out;
        logic [CODE_W-1:0] sub_out;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // load transfers the pre-write input contents
        if (load_i) begin
            s_d.main_out = s_q.main_in;
            s_d.sub_out  = s_q.sub_in;
            if (s_q.ctl.clr_pend) begin
                s_d.main_in      = clr_val_i;
                s_d.main_out     = clr_val_i;
                s_d.ctl.clr_pend = 1'b0;
            end
        end
        if (sys_clr_i) begin
            s_d.main_in  = sys_clr_val_i;
            s_d.main_out = sys_clr_val_i;
        end
        if (ctl_we_i) begin
            s_d.ctl.bias     = ctl_wdata_i[CH_BIAS_LSB +: CH_BIAS_W];
            s_d.ctl.sub_sel  = ctl_wdata_i[CH_SUB_BIT];
            s_d.ctl.stby     = ctl_wdata_i[CH_STBY_BIT];
            s_d.ctl.clr_pend = ctl_wdata_i[CH_CLR_BIT];
        end
        if (code_we_i) begin
            if (code_sub_i) s_d.sub_in  = code_val_i;
            else            s_d.main_in = code_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o  = s_q.ctl;
    assign main_o = s_q.main_out;
    assign sub_o  = s_q.sub_out;

endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CODE_W = 10,
    localparam int AW    = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic                    mode_i,
    input  logic                    sel_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [CODE_W-1:0]       data_i,
    input  logic                    load_i,
    output logic                    fmt_byte_o,
    output logic                    coding_twos_o,
    output logic                    pwrdn_o,
    output logic [NCH-1:0]          chan_off_o,
    output logic [2*NCH-1:0]        bias_sel_o,
    output logic [NCH-1:0]          clr_pend_o,
    output logic [NCH*CODE_W-1:0]   main_code_o,
    output logic [NCH*CODE_W-1:0]   sub_code_o
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    sys_ctrl_t         sys_d, sys_q;
    logic              sys_we, sys_clr, dat_we;
    logic [NCH-1:0]    chctl_we, code_we, sub_sel;
    logic              code_sub;
    logic [CODE_W-1:0] code_val, clr_val, sys_clr_val;
    ch_ctrl_t          ctl_w [NCH];

    dacif_decode #(.NCH(NCH)) u_decode (
        .wr_i       (wr_i),
        .mode_i     (mode_i),
        .sel_i      (sel_i),
        .addr_i     (addr_i),
        .clr_bit_i  (data_i[SYS_CLR_BIT]),
        .sys_we_o   (sys_we),
        .sys_clr_o  (sys_clr),
        .chctl_we_o (chctl_we),
        .dat_we_o   (dat_we)
    );

    always_comb begin
        sys_d = sys_q;
        if (sys_we) begin
            sys_d.byte_fmt = data_i[SYS_BYTE_BIT];
            sys_d.twos     = data_i[SYS_TWOS_BIT];
            sys_d.pwrdn    = data_i[SYS_PD_BIT];
            sys_d.pkg_stby = data_i[SYS_STBY_BIT];
        end
        clr_val     = sys_q.twos ? MID_CODE : '0;
        sys_clr_val = data_i[SYS_TWOS_BIT] ? MID_CODE : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q          <= '0;
            sys_q.pkg_stby <= 1'b1;
        end else begin
            sys_q <= sys_d;
        end
    end

    dacif_assemble #(.NCH(NCH), .CODE_W(CODE_W)) u_assemble (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat_we_i   (dat_we),
        .sys_we_i   (sys_we),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .byte_fmt_i (sys_q.byte_fmt),
        .twos_i     (sys_q.twos),
        .sub_sel_i  (sub_sel),
        .code_we_o  (code_we),
        .code_sub_o (code_sub),
        .code_val_o (code_val)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dacif_channel #(.CODE_W(CODE_W)) u_channel (
            .clk           (clk),
            .rst_n         (rst_n),
            .ctl_we_i      (chctl_we[i]),
            .ctl_wdata_i   (data_i[CTL_W-1:0]),
            .code_we_i     (code_we[i]),
            .code_sub_i    (code_sub),
            .code_val_i    (code_val),
            .load_i        (load_i),
            .clr_val_i     (clr_val),
            .sys_clr_i     (sys_clr),
            .sys_clr_val_i (sys_clr_val),
            .ctl_o         (ctl_w[i]),
            .main_o        (main_code_o[i*CODE_W +: CODE_W]),
            .sub_o         (sub_code_o[i*CODE_W +: CODE_W])
        );
        assign sub_sel[i]          = ctl_w[i].sub_sel;
        assign bias_sel_o[2*i +: 2] = ctl_w[i].bias;
        assign clr_pend_o[i]       = ctl_w[i].clr_pend;
        assign chan_off_o[i]       = sys_q.pwrdn | sys_q.pkg_stby | ctl_w[i].stby;
    end

    assign fmt_byte_o    = sys_q.byte_fmt;
    assign coding_twos_o = sys_q.twos;
    assign pwrdn_o       = sys_q.pwrdn;

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
    parameter int NCH    = 8,
    parameter int CODE_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_i,
    input logic                  mode_i,
    input logic                  load_i,
    input logic                  sys_clr,
    input logic                  coding_twos_o,
    input logic                  pwrdn_o,
    input logic [NCH-1:0]        chan_off_o,
    input logic [2*NCH-1:0]      bias_sel_o,
    input logic [NCH-1:0]        clr_pend_o,
    input logic [NCH*CODE_W-1:0] main_code_o,
    input logic [NCH*CODE_W-1:0] sub_code_o
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] LOW_CODE = '0;

    // R4
    main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !sys_clr) |=> $stable(main_code_o));

    // R5
    sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sub_code_o));

    // R3
    pwrdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> (&chan_off_o));

    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i || mode_i) |=> ($stable(bias_sel_o) && $stable(chan_off_o)));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R9
        sys_clear_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sys_clr |=> main_code_o[c*CODE_W +: CODE_W] ==
                        (coding_twos_o ? MID_CODE : LOW_CODE));

        // R8
        chan_clear_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && clr_pend_o[c] && !sys_clr) |=>
                main_code_o[c*CODE_W +: CODE_W] ==
                ($past(coding_twos_o) ? MID_CODE : LOW_CODE));
    end

endmodule

bind dacif_top dacif_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_dacif_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (wr_i),
    .mode_i        (mode_i),
    .load_i        (load_i),
    .sys_clr       (sys_clr),
    .coding_twos_o (coding_twos_o),
    .pwrdn_o       (pwrdn_o),
    .chan_off_o    (chan_off_o),
    .bias_sel_o    (bias_sel_o),
    .clr_pend_o    (clr_pend_o),
    .main_code_o   (main_code_o),
    .sub_code_o    (sub_code_o)
);

// File: tb/test_dacif_top.sv
`timescale 1ns/1ps
module test_dacif_top;

    localparam int NCH = 8;
    localparam int CW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_i = 1'b0, mode_i = 1'b0, sel_i = 1'b0, load_i = 1'b0;
    logic [2:0]      addr_i = '0;
    logic [CW-1:0]   data_i = '0;
    logic            fmt_byte_o, coding_twos_o, pwrdn_o;
    logic [NCH-1:0]  chan_off_o, clr_pend_o;
    logic [2*NCH-1:0] bias_sel_o;
    logic [NCH*CW-1:0] main_code_o, sub_code_o;

    always #2 clk = ~clk;

    dacif_top i_dacif_top (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .mode_i(mode_i), .sel_i(sel_i),
        .addr_i(addr_i), .data_i(data_i), .load_i(load_i),
        .fmt_byte_o(fmt_byte_o), .coding_twos_o(coding_twos_o), .pwrdn_o(pwrdn_o),
        .chan_off_o(chan_off_o), .bias_sel_o(bias_sel_o), .clr_pend_o(clr_pend_o),
        .main_code_o(main_code_o), .sub_code_o(sub_code_o)
    );

    // scoreboard item: kind 0 main,1 sub,2 off,3 bias,4 pend,5 pwrdn,6 byte,7 twos
    typedef struct {
        int    kind;
        int    ch;
        int    exp;
        string tag;
    } item_t;
    item_t q[$];

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference state
    int m_in[NCH], s_in[NCH], m_out[NCH], s_out[NCH];
    int bias[NCH];
    bit subsel[NCH], stby[NCH], pend[NCH];
    bit b_fmt = 0, twos = 0, pd = 0, pstby = 1, second = 0;
    int lo = 0;

    function automatic int clr_of(bit t);
        return t ? 512 : 0;
    endfunction

    task automatic model(bit wr, bit mode, bit sel, int addr, logic [9:0] d, bit ld);
        int code;
        bit fire, tgt;
        if (ld) for (int c = 0; c < NCH; c++) begin
            m_out[c] = m_in[c];
            s_out[c] = s_in[c];
            if (pend[c]) begin
                m_in[c] = clr_of(twos); m_out[c] = m_in[c]; pend[c] = 0;
            end
        end
        if (!wr) return;
        fire = 0; tgt = 0; code = 0;
        if (!mode && !sel) begin
            b_fmt = d[0]; twos = d[1]; pd = d[2]; pstby = d[3]; second = 0;
            if (d[4]) for (int c = 0; c < NCH; c++) begin
                m_in[c] = clr_of(twos); m_out[c] = m_in[c];
            end
        end else if (!mode) begin
            bias[addr] = d[1:0]; subsel[addr] = d[2]; stby[addr] = d[3]; pend[addr] = d[4];
        end else if (!b_fmt) begin
            code = d; tgt = subsel[addr]; fire = 1;
        end else if (!second) begin
            lo = d[7:0]; second = 1;
        end else begin
            code = {d[2:1], 8'(lo)}; tgt = d[0]; second = 0; fire = 1;
        end
        if (fire) begin
            if (twos) code = code ^ 512;
            if (tgt) s_in[addr] = code; else m_in[addr] = code;
        end
    endtask

    task automatic push_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            q.push_back('{0, c, m_out[c], tag});
            q.push_back('{1, c, s_out[c], tag});
            q.push_back('{2, c, int'(pd | pstby | stby[c]), tag});
            q.push_back('{3, c, bias[c], tag});
            q.push_back('{4, c, int'(pend[c]), tag});
        end
        q.push_back('{5, 0, int'(pd), tag});
        q.push_back('{6, 0, int'(b_fmt), tag});
        q.push_back('{7, 0, int'(twos), tag});
    endtask

    task automatic op(bit wr, bit mode, bit sel, int addr, int d, bit ld, string tag);
        @(posedge clk);
        #1;
        wr_i = wr; mode_i = mode; sel_i = sel; addr_i = 3'(addr);
        data_i = CW'(d); load_i = ld;
        @(posedge clk);
        #1;
        wr_i = 0; mode_i = 0; sel_i = 0; addr_i = '0; data_i = '0; load_i = 0;
        model(wr, mode, sel, addr, 10'(d), ld);
        push_all(tag);
    endtask

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            case (it.kind)
                0: act = int'(main_code_o[it.ch*CW +: CW]);
                1: act = int'(sub_code_o[it.ch*CW +: CW]);
                2: act = int'(chan_off_o[it.ch]);
                3: act = int'(bias_sel_o[2*it.ch +: 2]);
                4: act = int'(clr_pend_o[it.ch]);
                5: act = int'(pwrdn_o);
                6: act = int'(fmt_byte_o);
                default: act = int'(coding_twos_o);
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d ch=%0d actual=0x%0h expected=0x%0h",
                         it.tag, it.kind, it.ch, act, it.exp);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_in[c] = 0; s_in[c] = 0; m_out[c] = 0; s_out[c] = 0;
            bias[c] = 0; subsel[c] = 0; stby[c] = 0; pend[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_all("R1");
        // system: word format, offset binary, active
        op(1, 0, 0, 0, 'h000, 0, "R3");
        // channel 2: bias 2, standby; others untouched
        op(1, 0, 1, 2, 'h00A, 0, "R2");
        // word write to main, visible only after load
        op(1, 1, 0, 0, 'h155, 0, "R4");
        op(0, 0, 0, 0, 0, 1, "R4");
        // route channel 1 to sub
        op(1, 0, 1, 1, 'h004, 0, "R5");
        op(1, 1, 0, 1, 'h2AA, 0, "R5");
        op(0, 0, 0, 0, 0, 1, "R5");
        // load with nothing new, data write leaves control alone
        op(0, 0, 0, 0, 0, 1, "R10");
        op(1, 1, 0, 2, 'h3FF, 0, "R10");
        // same-cycle load and write
        op(1, 1, 0, 5, 'h111, 0, "R12");
        op(1, 1, 0, 5, 'h0F0, 1, "R12");
        op(0, 0, 0, 0, 0, 1, "R12");
        // twos complement word write
        op(1, 0, 0, 0, 'h002, 0, "R6");
        op(1, 1, 0, 3, 'h005, 0, "R6");
        op(0, 0, 0, 0, 0, 1, "R6");
        // sub code on channel 0, then channel clear
        op(1, 0, 1, 0, 'h004, 0, "R8");
        op(1, 1, 0, 0, 'h077, 0, "R8");
        op(1, 0, 1, 0, 'h010, 0, "R8");
        op(0, 0, 0, 0, 0, 1, "R8");
        // system clear with offset binary coding
        op(1, 0, 0, 0, 'h010, 0, "R9");
        // byte format: main then sub
        op(1, 0, 0, 0, 'h001, 0, "R7");
        op(1, 1, 0, 4, 'h034, 0, "R7");
        op(1, 1, 0, 4, 'h004, 0, "R7");
        op(0, 0, 0, 0, 0, 1, "R7");
        op(1, 1, 0, 4, 'h012, 0, "R7");
        op(1, 1, 0, 4, 'h003, 0, "R7");
        op(0, 0, 0, 0, 0, 1, "R7");
        // system write restarts byte sequence
        op(1, 1, 0, 6, 'h055, 0, "R11");
        op(1, 0, 0, 0, 'h001, 0, "R11");
        op(1, 1, 0, 6, 'h066, 0, "R11");
        op(1, 1, 0, 6, 'h002, 0, "R11");
        op(0, 0, 0, 0, 0, 1, "R11");
        // byte format with twos complement
        op(1, 0, 0, 0, 'h003, 0, "R6");
        op(1, 1, 0, 7, 'h000, 0, "R6");
        op(1, 1, 0, 7, 'h000, 0, "R6");
        op(0, 0, 0, 0, 0, 1, "R6");
        // twos system clear, then power-down
        op(1, 0, 0, 0, 'h012, 0, "R9");
        op(1, 0, 0, 0, 'h004, 0, "R3");
        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule